// File: doc/BRIEF.md
# Hardware Counting Semaphore Unit

This block holds a small bank of shared signed counting semaphores and applies wait (P), signal (V) and load (INIT) operations to them on behalf of several requester ports. Each operation is applied as one indivisible update to one semaphore. A caller whose wait drives a count below zero is parked in that semaphore's queue of port IDs. It stays parked until a later signal hands the semaphore to it, so it never spins on a lock.

Each port presents a request with valid/ready handshaking. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` must not depend on `req_ready`, and a port holds its request fields stable until it is accepted. `req_ready` can only be high for a port that asserts `req_valid` and is not blocked. A blocked port sees `req_ready` low until it is woken, which is how back-pressure reaches it. Completion is a one-cycle `done` pulse per port. `op_count` reports the count left by the most recent accepted operation.

Op encoding on `req_op`: 2'b00 = P, 2'b01 = V, 2'b10 = INIT, 2'b11 = no-op.

Top module: `sem_unit`

## Requirements
- R1: After reset every count is 0, every queue is empty, and `blocked`, `done` and `op_count` are all zero. With no valid request, `req_ready` is zero.
- R2: A P on a count greater than 0 decrements the count. The next cycle shows the caller's `done` high and `op_count` equal to the new count.
- R3: A P on a count of 0 or less decrements the count and raises the caller's `blocked` bit in the next cycle, with no `done`. While `blocked` is high, the port's `req_ready` stays low and its requests have no effect.
- R4: A V increments the count and pulses the caller's `done`. If the old count was negative, the head waiter's `blocked` bit clears and its `done` pulses in that same cycle.
- R5: Waiters on one semaphore are resumed in the order they blocked. A V on one semaphore never wakes a waiter of another.
- R6: At most one request is accepted per cycle. Among simultaneous requests, the first eligible port after the last accepted one, in ascending cyclic order, wins.
- R7: INIT loads its value into the count, with a negative value loaded as 0. It also releases every waiter of that semaphore, pulsing their `done` together with the caller's.
- R8: A V on a count at the largest positive value leaves it unchanged.
- R9: A negative count always equals minus the number of waiters queued on that semaphore, and a non-negative count has an empty queue.
- R10: Op 2'b11 completes with `done` and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Per-port request valid |
| req_ready | output | NPORTS | Per-port request accepted this cycle |
| req_op | input | 2*NPORTS | Per-port op, port p at bits [2p+1:2p] |
| req_sem | input | SEM_W*NPORTS | Per-port semaphore index |
| req_val | input | CNT_W*NPORTS | Per-port INIT value (signed) |
| done | output | NPORTS | One-cycle completion or wakeup pulse |
| blocked | output | NPORTS | Port is parked in a wait queue |
| op_count | output | CNT_W | Signed count after the last accepted op |

## Verification
The hardest situation to reach is a semaphore with several waiters parked at once, followed by wakeups whose order must match blocking order. The stimulus gets there by first draining a mutex with P from one port and then issuing P from every other port in turn. After that, single V operations are applied one at a time, and each one must free exactly the next queued port. The INIT flush uses the same method: two ports are parked first, and the bench then checks that both are released in the same cycle.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OP_WAIT   = 2'b00,
    OP_SIGNAL = 2'b01,
    OP_LOAD   = 2'b10,
    OP_NOP    = 2'b11
  } sem_op_e;
endpackage

// File: rtl/sem_rr_arb.sv
module sem_rr_arb #(
  parameter int NREQ = 4,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] grant,
  output logic [IW-1:0]   gid,
  output logic            any
);
  logic [IW-1:0] last_q;

  always_comb begin
    grant = '0;
    gid   = '0;
    any   = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NREQ;
      if (!any && req[idx]) begin
        any        = 1'b1;
        grant[idx] = 1'b1;
        gid        = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= IW'(NREQ - 1);
    else if (any) last_q <= gid;
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R6
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  // R6
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !any);
endmodule

// File: rtl/sem_wait_fifo.sv
module sem_wait_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_id,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [OW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [OW-1:0] occ_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      occ_q <= occ_q + 1'b1;
      else if (pop && !push) occ_q <= occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= push_id;
  end

  assign head = mem[rd_q];
  assign occ  = occ_q;

  // R9
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (int'(occ_q) < DEPTH));
  // R5
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> (occ_q != '0));
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NSEM   = 4,
  parameter int CNT_W  = 8,
  localparam int ID_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int SEM_W = (NSEM > 1) ? $clog2(NSEM) : 1,
  localparam int OCC_W = $clog2(NPORTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORTS-1:0]       req_valid,
  output logic [NPORTS-1:0]       req_ready,
  input  logic [2*NPORTS-1:0]     req_op,
  input  logic [SEM_W*NPORTS-1:0] req_sem,
  input  logic [CNT_W*NPORTS-1:0] req_val,
  output logic [NPORTS-1:0]       done,
  output logic [NPORTS-1:0]       blocked,
  output logic [CNT_W-1:0]        op_count
);
  localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};

  logic signed [CNT_W-1:0] cnt_q [NSEM];
  logic [SEM_W-1:0]        wsem_q [NPORTS];
  logic [NPORTS-1:0]       blk_q, done_q;
  logic [CNT_W-1:0]        opc_q;

  logic [NPORTS-1:0] grant;
  logic [ID_W-1:0]   gid;
  logic              fire;

  sem_rr_arb #(.NREQ(NPORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid & ~blk_q),
    .grant(grant), .gid(gid), .any(fire));

  assign req_ready = grant;

  sem_op_e                 sel_op;
  logic [SEM_W-1:0]        sel_sem;
  logic signed [CNT_W-1:0] sel_val, cur, nxt;

  always_comb begin
    sel_op  = sem_op_e'(req_op[gid*2 +: 2]);
    sel_sem = req_sem[gid*SEM_W +: SEM_W];
    sel_val = req_val[gid*CNT_W +: CNT_W];
    cur     = cnt_q[sel_sem];
  end

  logic [ID_W-1:0]  head_w [NSEM];
  logic [OCC_W-1:0] occ_w  [NSEM];
  logic [NSEM-1:0]  push_v, pop_v, flush_v;

  genvar gs;
  generate
    for (gs = 0; gs < NSEM; gs++) begin : g_q
      sem_wait_fifo #(.DEPTH(NPORTS), .DW(ID_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush_v[gs]),
        .push(push_v[gs]), .push_id(gid), .pop(pop_v[gs]),
        .head(head_w[gs]), .occ(occ_w[gs]));
    end
  endgenerate

  logic [NPORTS-1:0] set_blk, clr_blk, done_d;

  always_comb begin
    nxt     = cur;
    push_v  = '0;
    pop_v   = '0;
    flush_v = '0;
    set_blk = '0;
    clr_blk = '0;
    done_d  = '0;
    if (fire) begin
      unique case (sel_op)
        OP_WAIT: begin
          nxt = cur - 1'b1;
          if (nxt < 0) begin
            push_v[sel_sem] = 1'b1;
            set_blk[gid]    = 1'b1;
          end else begin
            done_d[gid] = 1'b1;
          end
        end
        OP_SIGNAL: begin
          nxt         = (cur == CMAX) ? cur : cur + 1'b1;
          done_d[gid] = 1'b1;
          if (cur < 0) begin
            pop_v[sel_sem]          = 1'b1;
            clr_blk[head_w[sel_sem]] = 1'b1;
            done_d[head_w[sel_sem]]  = 1'b1;
          end
        end
        OP_LOAD: begin
          nxt              = (sel_val < 0) ? '0 : sel_val;
          flush_v[sel_sem] = 1'b1;
          done_d[gid]      = 1'b1;
          for (int p = 0; p < NPORTS; p++) begin
            if (blk_q[p] && wsem_q[p] == sel_sem) begin
              clr_blk[p] = 1'b1;
              done_d[p]  = 1'b1;
            end
          end
        end
        default: done_d[gid] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSEM; s++) cnt_q[s] <= '0;
      for (int p = 0; p < NPORTS; p++) wsem_q[p] <= '0;
      blk_q  <= '0;
      done_q <= '0;
      opc_q  <= '0;
    end else begin
      done_q <= done_d;
      blk_q  <= (blk_q & ~clr_blk) | set_blk;
      if (fire) begin
        cnt_q[sel_sem] <= nxt;
        opc_q          <= nxt;
        if (set_blk[gid]) wsem_q[gid] <= sel_sem;
      end
    end
  end

  assign done     = done_q;
  assign blocked  = blk_q;
  assign op_count = opc_q;

  generate
    for (gs = 0; gs < NSEM; gs++) begin : g_inv
      // R9
      neg_matches_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[gs] < 0) |-> (CNT_W'(occ_w[gs]) == CNT_W'(-cnt_q[gs])));
      // R9
      pos_empty_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[gs] >= 0) |-> (occ_w[gs] == '0));
    end
  endgenerate

  // R3
  blocked_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & blk_q) == '0);
  // R3
  wait_parks_caller_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_WAIT && cur <= 0) |=> blk_q[$past(gid)]);
  // R4
  done_excludes_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q & blk_q) == '0);
  // R8
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_op == OP_SIGNAL && cur == CMAX) |=> (signed'(opc_q) == CMAX));
endmodule

// File: tb/test_sem_unit.sv
module test_sem_unit;
  localparam int NP = 4, NS = 4, CW = 8, SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [NP-1:0] req_ready;
  logic [2*NP-1:0]  req_op = '0;
  logic [SW*NP-1:0] req_sem = '0;
  logic [CW*NP-1:0] req_val = '0;
  logic [NP-1:0] done, blocked;
  logic [CW-1:0] op_count;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sem_unit #(.NPORTS(NP), .NSEM(NS), .CNT_W(CW)) i_sem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_sem(req_sem), .req_val(req_val),
    .done(done), .blocked(blocked), .op_count(op_count));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {port, op, sem, val, done, blocked, op_count}
  localparam int VN = 20;
  localparam logic [29:0] VECS [VN] = '{
    {2'd0, 2'd2, 2'd0, 8'd1,    4'b0001, 4'b0000, 8'd1},    // R7 mutex
    {2'd0, 2'd0, 2'd0, 8'd0,    4'b0001, 4'b0000, 8'd0},    // R2
    {2'd1, 2'd0, 2'd0, 8'd0,    4'b0000, 4'b0010, 8'hFF},   // R3
    {2'd2, 2'd0, 2'd0, 8'd0,    4'b0000, 4'b0110, 8'hFE},   // R3
    {2'd3, 2'd0, 2'd0, 8'd0,    4'b0000, 4'b1110, 8'hFD},   // R9
    {2'd0, 2'd1, 2'd0, 8'd0,    4'b0011, 4'b1100, 8'hFE},   // R4 R5
    {2'd0, 2'd1, 2'd0, 8'd0,    4'b0101, 4'b1000, 8'hFF},   // R5
    {2'd0, 2'd1, 2'd0, 8'd0,    4'b1001, 4'b0000, 8'd0},    // R5
    {2'd0, 2'd1, 2'd0, 8'd0,    4'b0001, 4'b0000, 8'd1},    // R4
    {2'd1, 2'd2, 2'd1, 8'hFB,   4'b0010, 4'b0000, 8'd0},    // R7 clamp
    {2'd1, 2'd0, 2'd1, 8'd0,    4'b0000, 4'b0010, 8'hFF},   // R3
    {2'd2, 2'd0, 2'd1, 8'd0,    4'b0000, 4'b0110, 8'hFE},   // R3
    {2'd0, 2'd2, 2'd1, 8'd3,    4'b0111, 4'b0000, 8'd3},    // R7 flush
    {2'd3, 2'd2, 2'd2, 8'd127,  4'b1000, 4'b0000, 8'd127},  // R7
    {2'd3, 2'd1, 2'd2, 8'd0,    4'b1000, 4'b0000, 8'd127},  // R8
    {2'd3, 2'd3, 2'd2, 8'd0,    4'b1000, 4'b0000, 8'd127},  // R10
    {2'd3, 2'd0, 2'd2, 8'd0,    4'b1000, 4'b0000, 8'd126},  // R2
    {2'd2, 2'd0, 2'd3, 8'd0,    4'b0000, 4'b0100, 8'hFF},   // R1 R3
    {2'd0, 2'd1, 2'd0, 8'd0,    4'b0001, 4'b0100, 8'd2},    // R5 other sem
    {2'd1, 2'd1, 2'd3, 8'd0,    4'b0110, 4'b0000, 8'd0}     // R4
  };

  task automatic issue(input int p, input logic [1:0] op, input logic [1:0] s, input logic [7:0] v);
    req_op[p*2 +: 2]   = op;
    req_sem[p*SW +: SW] = s;
    req_val[p*CW +: CW] = v;
    req_valid[p]       = 1'b1;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 blocked", 32'(blocked), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 op_count", 32'(op_count), 0);
    chk("R1 ready idle", 32'(req_ready), 0);

    for (int i = 0; i < VN; i++) begin
      logic [29:0] v;
      v = VECS[i];
      issue(int'(v[29:28]), v[27:26], v[25:24], v[23:16]);
      #1;
      chk("R6 ready", 32'(req_ready), 32'(1 << v[29:28]));
      @(negedge clk);
      req_valid = '0;
      chk("R2-R10 done", 32'(done), 32'(v[15:12]));
      chk("R3 blocked", 32'(blocked), 32'(v[11:8]));
      chk("R9 op_count", 32'(op_count), 32'(v[7:0]));
    end

    // R6: all four ports request at once; last accepted was port 1
    for (int p = 0; p < NP; p++) issue(p, 2'b11, 2'd0, 8'd0);
    for (int k = 0; k < NP; k++) begin
      int e;
      e = (2 + k) % NP;
      #1;
      chk("R6 rr grant", 32'(req_ready), 32'(1 << e));
      @(negedge clk);
      chk("R6 rr done", 32'(done), 32'(1 << e));
      req_valid[e] = 1'b0;
    end
    @(negedge clk);

    // R3: parked port's request is ignored
    issue(0, 2'b00, 2'd3, 8'd0);
    @(negedge clk);
    req_valid = '0;
    chk("R3 park", 32'(blocked), 32'b0001);
    chk("R3 park cnt", 32'(op_count), 32'hFF);
    issue(0, 2'b01, 2'd0, 8'd0);
    #1;
    chk("R3 ready low", 32'(req_ready), 0);
    repeat (2) @(negedge clk);
    chk("R3 ignored done", 32'(done), 0);
    chk("R3 ignored cnt", 32'(op_count), 32'hFF);
    req_valid = '0;

    // R1: reset clears a parked port and all counts
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset blocked", 32'(blocked), 0);
    chk("R1 reset cnt", 32'(op_count), 0);
    issue(1, 2'b01, 2'd0, 8'd0);
    @(negedge clk);
    req_valid = '0;
    chk("R1 reset sem0", 32'(op_count), 1);
    chk("R1 reset done", 32'(done), 32'b0010);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule